// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Streamer

This block is the control side of a serial configuration memory. It sends a stored bitstream to an FPGA configuration data input, one bit per configuration clock period. An internal bit address counter walks a small storage array, starting at bit 0. Inside each stored byte the least significant bit goes first. A byte-wide parallel write port loads the array in test. The block divides the system clock down to a configuration clock, and runs that clock whenever it is neither in power-on reset nor idle.

The host starts, pauses and restarts the stream with two inputs. One is a reset / output-enable input whose active level comes from a stored polarity bit. The other is an active-low chip select. When the last bit has left, the data output goes to high impedance and the cascade output goes low, so the chip select of a downstream device can take over. When chip select then rises, the block sends a fixed burst of further clock pulses so the FPGA can finish its start-up, and then stops the clock. Two protocol faults set a sticky error flag: chip select rising before the end of the data, and chip select still low too long after the end.

Top module: `cfg_stream_top`

## Requirements
- R1: While `rst_n` is low, and for `POR_CYCLES` clock cycles after it rises, `rdy_low` is 1 (the open-drain ready line is pulled), `sdata_en` is 0 and `cclk` is 0. After that `rdy_low` stays 0.
- R2: The reset input counts as asserted when `oe_rst` equals the stored polarity bit. That bit is written with `pol_we`/`pol_val` and resets to `DEF_POL` (0, so a low `oe_rst` asserts reset). While reset is asserted, `sdata_en` is 0 whatever `cs_n` is. The next stream after release starts again at bit 0, and `casc_n` returns to 1.
- R3: While `cs_n` is 1, `sdata_en` is 0 and the address counter holds. When `cs_n` returns low, the stream resumes at the bit that follows the last one presented.
- R4: With `cs_n` low and reset released, `sdata` presents stream bit k = bit (k mod 8) of stored byte k/8. The address advances at each falling edge of `cclk`, so each bit is stable across exactly one rising edge of `cclk`.
- R5: While running, `cclk` has a period of `CLK_DIV` system clocks and is high for `CLK_DIV/2` of them.
- R6: After the last of the `DEPTH` bits has been presented, `casc_n` goes to 0 and `sdata_en` to 0. Both stay there until reset is asserted.
- R7: After the end of data, once `cs_n` is 1, exactly `TAIL_PULSES` (16) more rising edges appear on `cclk`. After that `cclk` stays 0 until reset is asserted.
- R8: `cfg_err` is set if `cs_n` is 1 in the streaming phase after the address has moved off bit 0.
- R9: If `cs_n` stays low after the end of data, `cfg_err` is set at the `GRACE`-th falling edge of `cclk` after the end, and not before. Raising `cs_n` earlier than that raises no error.
- R10: `cfg_err` stays set until reset is asserted, which clears it.
- R11: A write with `wr_en` high stores `wr_data` as byte `wr_addr` of the array, and that byte is the one streamed later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Test write strobe for the storage array |
| wr_addr | input | $clog2(DEPTH/8) | Byte address for the test write |
| wr_data | input | 8 | Byte to store |
| pol_we | input | 1 | Write strobe for the reset polarity bit |
| pol_val | input | 1 | New polarity: 1 means `oe_rst` high asserts reset |
| oe_rst | input | 1 | Reset / output-enable input, polarity programmable |
| cs_n | input | 1 | Chip select, active low |
| cclk | output | 1 | Configuration clock |
| sdata | output | 1 | Serial data value (0 when not driven) |
| sdata_en | output | 1 | Serial data output enable (0 = high impedance) |
| casc_n | output | 1 | Cascade output, low once all data is sent |
| rdy_low | output | 1 | Pull-down control of the open-drain ready line |
| cfg_err | output | 1 | Sticky configuration sequence error |

## Verification
Some behaviours are checked by assertions on every cycle. The output enable must stay off under reset, in standby and after the cascade handoff. The address must hold in standby and step by one at each falling tick. Reset must clear the address and the error. The error flag and the end-of-data state must be sticky. The tail pulse count must stay within bounds. The clock must follow its rise and fall ticks and stay low when stopped. Other behaviours only show up in the bench scenarios, because they depend on the stored contents and the host's timing. These are the bit order of the stream and its resumption after a pause, restart from bit 0 after a mid-stream reset, and both polarity settings. They also include the exact count of 16 trailing pulses and the exact falling edge at which the grace-period error appears.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

   // sequencer phases
   typedef enum logic [2:0] {
      ST_POR  = 3'd0,   // power-on interval
      ST_RUN  = 3'd1,   // streaming or standby
      ST_DONE = 3'd2,   // all bits sent, waiting for chip select to rise
      ST_TAIL = 3'd3,   // trailing clock burst
      ST_IDLE = 3'd4    // clock stopped
   } seq_state_e;

endpackage

// File: rtl/cfgs_clkgen.sv
module cfgs_clkgen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic cclk,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam int HALF = CLK_DIV / 2;

   logic [CW-1:0] cnt;
   logic [CW-1:0] nxt;

   initial begin : chk_div
      assert (CLK_DIV >= 2 && (CLK_DIV % 2) == 0)
         else $fatal(1, "CLK_DIV must be even and at least 2");
   end

   always_comb begin
      if (cnt == CW'(CLK_DIV - 1)) nxt = '0;
      else                         nxt = cnt + 1'b1;
   end

   // ticks announce what the next edge does to cclk
   assign rise_tick = run && (cnt == CW'(HALF - 1));
   assign fall_tick = run && (cnt == CW'(CLK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         cclk <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         cclk <= 1'b0;
      end else begin
         cnt  <= nxt;
         cclk <= (nxt >= CW'(HALF));
      end
   end

   assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise_tick |=> cclk);
   assert_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall_tick |=> !cclk);
   assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !cclk);

endmodule

// File: rtl/cfgs_bitstore.sv
module cfgs_bitstore #(
   parameter int DEPTH     = 256,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                         clk,
   input  logic                         wr_en,
   input  logic [$clog2(DEPTH/8)-1:0]   wr_addr,
   input  logic [7:0]                   wr_data,
   input  logic [$clog2(DEPTH)-1:0]     rd_addr,
   output logic                         rd_bit
);
   localparam int AW     = $clog2(DEPTH);
   localparam int BAW    = $clog2(DEPTH / 8);
   localparam int NBYTES = DEPTH / 8;

   logic [7:0]     mem [NBYTES];
   logic [BAW-1:0] byte_sel;
   logic [2:0]     bit_sel;
   logic [7:0]     cur_byte;

   initial begin : chk_depth
      assert (DEPTH >= 16 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "DEPTH must be a power of two of at least 16");
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign byte_sel = rd_addr[AW-1:3];
   assign bit_sel  = rd_addr[2:0];
   assign cur_byte = mem[byte_sel];

   generate
      if (LSB_FIRST) begin : g_lsb
         assign rd_bit = cur_byte[bit_sel];
      end else begin : g_msb
         assign rd_bit = cur_byte[3'd7 - bit_sel];
      end
   endgenerate

endmodule

// File: rtl/cfgs_por.sv
module cfgs_por #(
   parameter int POR_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic busy
);
   localparam int PW = $clog2(POR_CYCLES + 1);

   logic [PW-1:0] cnt;

   initial begin : chk_por
      assert (POR_CYCLES >= 1) else $fatal(1, "POR_CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (cnt != PW'(POR_CYCLES))   cnt <= cnt + 1'b1;
   end

   assign busy = (cnt != PW'(POR_CYCLES));

   assert_por_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !busy);

endmodule

// File: rtl/cfgs_seq.sv
module cfgs_seq
   import cfg_stream_pkg::*;
#(
   parameter int DEPTH       = 256,
   parameter int GRACE       = 4,
   parameter int TAIL_PULSES = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     por_busy,
   input  logic                     rst_act,
   input  logic                     cs_n,
   input  logic                     rise_tick,
   input  logic                     fall_tick,
   output logic [$clog2(DEPTH)-1:0] addr,
   output logic                     drive,
   output logic                     done,
   output logic                     run,
   output logic                     err
);
   localparam int AW = $clog2(DEPTH);
   localparam int GW = $clog2(GRACE + 1);
   localparam int TW = $clog2(TAIL_PULSES + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   seq_state_e    state;
   logic [GW-1:0] grace;
   logic [TW-1:0] tail;

   initial begin : chk_counts
      assert (GRACE >= 1 && TAIL_PULSES >= 1)
         else $fatal(1, "GRACE and TAIL_PULSES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_POR;
         addr  <= '0;
         grace <= '0;
         tail  <= '0;
         err   <= 1'b0;
      end else if (state == ST_POR) begin
         if (!por_busy) state <= ST_RUN;
      end else if (rst_act) begin
         state <= ST_RUN;
         addr  <= '0;
         grace <= '0;
         tail  <= '0;
         err   <= 1'b0;
      end else begin
         case (state)
            ST_RUN: begin
               if (cs_n) begin
                  if (addr != '0) err <= 1'b1;
               end else if (fall_tick) begin
                  if (addr == LAST) begin
                     state <= ST_DONE;
                     grace <= '0;
                  end else begin
                     addr <= addr + 1'b1;
                  end
               end
            end
            ST_DONE: begin
               if (cs_n) begin
                  state <= ST_TAIL;
                  tail  <= rise_tick ? TW'(1) : '0;
               end else if (fall_tick) begin
                  if (grace == GW'(GRACE - 1)) err <= 1'b1;
                  else                         grace <= grace + 1'b1;
               end
            end
            ST_TAIL: begin
               if (fall_tick && tail == TW'(TAIL_PULSES)) state <= ST_IDLE;
               else if (rise_tick)                       tail  <= tail + 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign drive = (state == ST_RUN) && !cs_n && !rst_act;
   assign done  = (state == ST_DONE) || (state == ST_TAIL) || (state == ST_IDLE);
   assign run   = (state != ST_POR) && (state != ST_IDLE);

   assert_rst_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_POR && rst_act) |=> (addr == '0 && !err));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && cs_n && !rst_act) |=> $stable(addr));
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !cs_n && !rst_act && fall_tick && addr != LAST)
         |=> (addr == $past(addr) + 1'b1));
   assert_end_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rst_act) |=> done);
   assert_tail_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tail <= TW'(TAIL_PULSES));
   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !rst_act) |=> err);

endmodule

// File: rtl/cfg_stream_top.sv
module cfg_stream_top #(
   parameter int DEPTH       = 256,
   parameter int CLK_DIV     = 4,
   parameter int POR_CYCLES  = 8,
   parameter int GRACE       = 4,
   parameter int TAIL_PULSES = 16,
   parameter bit DEF_POL     = 1'b0,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(DEPTH/8)-1:0] wr_addr,
   input  logic [7:0]                 wr_data,
   input  logic                       pol_we,
   input  logic                       pol_val,
   input  logic                       oe_rst,
   input  logic                       cs_n,
   output logic                       cclk,
   output logic                       sdata,
   output logic                       sdata_en,
   output logic                       casc_n,
   output logic                       rdy_low,
   output logic                       cfg_err
);
   localparam int AW = $clog2(DEPTH);

   logic          pol_q;
   logic          rst_act;
   logic          por_busy;
   logic          run;
   logic          rise_tick;
   logic          fall_tick;
   logic [AW-1:0] addr;
   logic          drive;
   logic          done;
   logic          rd_bit;

   // stored reset polarity: 1 = high level on oe_rst asserts reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pol_q <= DEF_POL;
      else if (pol_we) pol_q <= pol_val;
   end

   assign rst_act = (oe_rst == pol_q);

   cfgs_por #(.POR_CYCLES(POR_CYCLES)) u_por (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (por_busy)
   );

   cfgs_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .cclk      (cclk),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   cfgs_seq #(
      .DEPTH       (DEPTH),
      .GRACE       (GRACE),
      .TAIL_PULSES (TAIL_PULSES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .por_busy  (por_busy),
      .rst_act   (rst_act),
      .cs_n      (cs_n),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .addr      (addr),
      .drive     (drive),
      .done      (done),
      .run       (run),
      .err       (cfg_err)
   );

   cfgs_bitstore #(.DEPTH(DEPTH), .LSB_FIRST(LSB_FIRST)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (addr),
      .rd_bit  (rd_bit)
   );

   assign sdata_en = drive;
   assign sdata    = drive & rd_bit;
   assign casc_n   = !done;
   assign rdy_low  = por_busy;

   assert_por_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_low |-> (!sdata_en && !cclk));
   assert_rst_tri_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_act |-> !sdata_en);
   assert_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sdata_en);
   assert_casc_tri_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !casc_n |-> !sdata_en);

endmodule

// File: tb/sim_cfg_stream_top.sv
module sim_cfg_stream_top;
   localparam int DEPTH = 256;
   localparam int DIV   = 4;
   localparam int PORC  = 8;
   localparam int GRACE = 4;
   localparam int TAILP = 16;
   localparam int BAW   = $clog2(DEPTH / 8);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [BAW-1:0] wr_addr = '0;
   logic [7:0]     wr_data = '0;
   logic           pol_we = 1'b0;
   logic           pol_val = 1'b0;
   logic           oe_rst = 1'b0;
   logic           cs_n = 1'b0;
   logic           cclk, sdata, sdata_en, casc_n, rdy_low, cfg_err;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;
   bit  exp_q[$];

   always #10 clk = ~clk;   // 50 MHz

   cfg_stream_top #(
      .DEPTH(DEPTH), .CLK_DIV(DIV), .POR_CYCLES(PORC),
      .GRACE(GRACE), .TAIL_PULSES(TAILP)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pol_we(pol_we), .pol_val(pol_val),
      .oe_rst(oe_rst), .cs_n(cs_n), .cclk(cclk), .sdata(sdata),
      .sdata_en(sdata_en), .casc_n(casc_n), .rdy_low(rdy_low),
      .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int sel, input int b);
      if (sel == 0) return 8'(b * 37 + 5);
      return 8'(b * 11) ^ 8'hA5;
   endfunction

   task automatic load_mem(input int sel);
      for (int b = 0; b < DEPTH / 8; b++) begin
         @(negedge clk);
         wr_en   = 1'b1;
         wr_addr = BAW'(b);
         wr_data = pat(sel, b);
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver side of the scoreboard: expected stream, LSB of byte 0 first
   task automatic push_expect(input int sel);
      logic [7:0] v;
      exp_q.delete();
      for (int k = 0; k < DEPTH; k++) begin
         v = pat(sel, k / 8);
         exp_q.push_back(v[k % 8]);
      end
   endtask

   task automatic align();
      @(negedge cclk);
      @(negedge clk);
   endtask

   // monitor: one sample per cclk rising edge while driven (R4, R11)
   initial begin
      bit e;
      forever begin
         @(posedge cclk);
         #1;
         if (sdata_en) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4 bit beyond end of stream", 1, 0);
            end else begin
               e = exp_q.pop_front();
               check(sdata == e, "R4/R11 stream bit", int'(sdata), int'(e));
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      longint t1, t2, t3;
      int     held, rises;
      logic   prev;

      // ---- reset state (R1)
      #3;
      check(rdy_low == 1'b1, "R1 ready pulled in reset", int'(rdy_low), 1);
      check(sdata_en == 1'b0, "R1 data off in reset", int'(sdata_en), 0);
      check(cclk == 1'b0, "R1 clock low in reset", int'(cclk), 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rdy_low == 1'b1, "R1 ready pulled during interval", int'(rdy_low), 1);
      load_mem(0);
      check(rdy_low == 1'b0, "R1 ready released", int'(rdy_low), 0);

      // ---- clock shape (R5)
      @(posedge cclk); t1 = $time;
      @(negedge cclk); t2 = $time;
      @(posedge cclk); t3 = $time;
      check((t3 - t1) == 20 * DIV, "R5 cclk period", int'(t3 - t1), 20 * DIV);
      check((t2 - t1) == 10 * DIV, "R5 cclk high time", int'(t2 - t1), 10 * DIV);

      // ---- reset asserted (default polarity: low asserts), cs_n low (R2)
      @(negedge clk);
      check(sdata_en == 1'b0, "R2 data off while reset low", int'(sdata_en), 0);
      check(casc_n == 1'b1, "R2 cascade high", int'(casc_n), 1);

      // ---- pass 1: stream with a standby pause (R3, R8, R10)
      push_expect(0);
      align();
      oe_rst = 1'b1;
      repeat (100) @(negedge cclk);
      @(negedge clk);
      check(cfg_err == 1'b0, "R8 no error while streaming", int'(cfg_err), 0);
      held = exp_q.size();
      cs_n = 1'b1;
      repeat (20) @(negedge clk);
      check(sdata_en == 1'b0, "R3 data off in standby", int'(sdata_en), 0);
      check(exp_q.size() == held, "R3 no bits during standby", exp_q.size(), held);
      check(cfg_err == 1'b1, "R8 early chip select rise", int'(cfg_err), 1);
      cs_n = 1'b0;
      wait (casc_n == 1'b0);
      #1;
      check(exp_q.size() == 0, "R6 all bits sent before cascade", exp_q.size(), 0);
      check(sdata_en == 1'b0, "R6 data off after end", int'(sdata_en), 0);
      repeat (10) @(negedge clk);
      check(casc_n == 1'b0, "R6 cascade stays low", int'(casc_n), 0);
      check(cfg_err == 1'b1, "R10 error sticky", int'(cfg_err), 1);

      // ---- pass 2: new contents, full stream, trailing burst (R7, R9, R10)
      load_mem(1);
      push_expect(1);
      @(negedge clk);
      oe_rst = 1'b0;
      repeat (4) @(negedge clk);
      check(cfg_err == 1'b0, "R10 reset clears error", int'(cfg_err), 0);
      check(casc_n == 1'b1, "R2 reset restarts cascade", int'(casc_n), 1);
      align();
      oe_rst = 1'b1;
      wait (casc_n == 1'b0);
      #1;
      check(exp_q.size() == 0, "R4 full stream consumed", exp_q.size(), 0);
      @(negedge clk);
      check(cfg_err == 1'b0, "R9 no error at end", int'(cfg_err), 0);
      cs_n  = 1'b1;
      rises = 0;
      prev  = cclk;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (cclk && !prev) rises++;
         prev = cclk;
      end
      check(rises == TAILP, "R7 trailing pulse count", rises, TAILP);
      check(cclk == 1'b0, "R7 clock stopped low", int'(cclk), 0);
      check(cfg_err == 1'b0, "R9 timely release gives no error", int'(cfg_err), 0);

      // ---- pass 3: high polarity, mid-stream reset, grace error (R2, R9)
      @(negedge clk);
      cs_n    = 1'b0;
      pol_we  = 1'b1;
      pol_val = 1'b1;
      @(negedge clk);
      pol_we  = 1'b0;
      push_expect(1);
      repeat (4) @(negedge clk);
      check(sdata_en == 1'b0, "R2 high oe_rst asserts reset", int'(sdata_en), 0);
      check(casc_n == 1'b1, "R2 cascade high after restart", int'(casc_n), 1);
      align();
      oe_rst = 1'b0;
      repeat (20) @(negedge cclk);
      @(negedge clk);
      oe_rst = 1'b1;
      #1;
      check(sdata_en == 1'b0, "R2 mid-stream reset tristates", int'(sdata_en), 0);
      push_expect(1);
      repeat (10) @(negedge clk);
      align();
      oe_rst = 1'b0;
      wait (casc_n == 1'b0);
      #1;
      check(exp_q.size() == 0, "R2 restart from bit 0 complete", exp_q.size(), 0);
      check(cfg_err == 1'b0, "R9 no error at end", int'(cfg_err), 0);
      repeat (GRACE - 1) @(negedge cclk);
      #1;
      check(cfg_err == 1'b0, "R9 no error inside grace", int'(cfg_err), 0);
      @(negedge cclk);
      #1;
      check(cfg_err == 1'b1, "R9 error at end of grace", int'(cfg_err), 1);
      repeat (8) @(negedge clk);
      check(cfg_err == 1'b1, "R10 grace error sticky", int'(cfg_err), 1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule